// File: doc/BRIEF.md
# Watchdog Timer with Timed-Unlock Control

This block is a watchdog peripheral for a small processor subsystem. It counts ticks of a slow watchdog clock, which reaches it as a one-cycle tick-enable pulse in the system clock domain. When the count reaches the selected timeout, it does one of two things. It raises an interrupt request, or it emits a one-cycle system reset request and sets a sticky reset-cause flag. Software restarts the count with a restart strobe, which is the watchdog-reset instruction of the CPU.

The configuration lives in a control/status register behind a simple one-cycle register port. The enable and timeout-select fields are protected. A write that sets both the change-enable bit and the reset-enable bit opens a short window. Only a write that lands inside this window may change those fields. The interrupt-enable bit is not protected. In interrupt-plus-reset mode, the first timeout gives an interrupt and the hardware clears the interrupt enable, so a second timeout without a restart resets the system.

The register port carries no valid/ready handshake and applies no back-pressure. Every write lands at the clock edge where `reg_wr` is high. Read data is a combinational view of the register that `reg_sel` selects.

Top module: `wdog_top`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x00, and `irq` and `sys_rst` are low.
- R2: The control register (`reg_sel`=0) holds the prescale select bits 2..0 at bits 2..0, reset enable at bit 3, change enable at bit 4, prescale select bit 3 at bit 5 and interrupt enable at bit 6. Bit 7 reads 0. The status register (`reg_sel`=1) holds the watchdog reset flag at bit 3, and its other bits read 0.
- R3: While the watchdog is running (reset enable or interrupt enable set), the timeout fires on the (2048 << select)-th tick after the count was last cleared. Cycles with `tick_en` low do not count.
- R4: A control write with bits 4 and 3 both set opens the unlock window. The reset-enable and prescale fields take a written value only if the write comes 1 to 4 cycles after the opening write. At any other time those fields keep their values. A write that takes effect closes the window and clears the count.
- R5: Bit 4 of the control register reads 1 while the window is open and 0 once it has closed.
- R6: A timeout with reset enable set and interrupt enable clear drives `sys_rst` high for exactly one cycle and sets the reset flag.
- R7: A `restart` pulse clears the count, so the next timeout comes one full period after the most recent restart.
- R8: A timeout with interrupt enable set raises `irq` and does not reset. If reset enable is also set, the hardware clears interrupt enable, so the next timeout resets.
- R9: `irq` stays high until `irq_ack` is pulsed or a control write with bit 6 clear is made.
- R10: Writing 0x00 through the unlock sequence stops the watchdog. After that, no reset, no interrupt and no flag change happen, however many ticks arrive.
- R11: Writing 0 to bit 3 of the status register clears the reset flag. Writing 1 there has no effect.
- R12: When `restart` and the tick that would end the period fall in the same cycle, the restart wins and no timeout occurs.
- R13: The interrupt-enable bit takes the written value on any control write, whether or not the window is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| restart | input | 1 | Count restart strobe |
| irq_ack | input | 1 | Interrupt acknowledge |
| tick_en | input | 1 | One-cycle watchdog clock tick |
| irq | output | 1 | Watchdog interrupt request |
| sys_rst | output | 1 | One-cycle system reset request |

## Verification
The critical coincidence is a `restart` strobe in the very cycle that carries the tick that would end the period. The bench brings the count to one tick short of the timeout and then asserts `restart` and `tick_en` together. It judges the result by the absence of any reset pulse, followed by exactly one pulse a full period later. A second overlap is the unlock window against the protected write. The bench places the protected write at distances of four and five cycles from the opening write and reads back the fields to see which one took effect.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W   = 8;
  localparam int SEL_W   = 4;
  // control register bit positions
  localparam int B_PS0   = 0;
  localparam int B_PS1   = 1;
  localparam int B_PS2   = 2;
  localparam int B_RE    = 3;
  localparam int B_CE    = 4;
  localparam int B_PS3   = 5;
  localparam int B_IE    = 6;
  // status register bit position
  localparam int B_FLAG  = 3;

  typedef struct packed {
    logic             ie;
    logic             re;
    logic [SEL_W-1:0] ps;
  } wdog_cfg_t;

  function automatic logic [REG_W-1:0] ctl_image(input wdog_cfg_t c, input logic ce);
    logic [REG_W-1:0] v;
    v        = '0;
    v[B_PS0] = c.ps[0];
    v[B_PS1] = c.ps[1];
    v[B_PS2] = c.ps[2];
    v[B_PS3] = c.ps[3];
    v[B_RE]  = c.re;
    v[B_CE]  = ce;
    v[B_IE]  = c.ie;
    return v;
  endfunction

  function automatic logic [SEL_W-1:0] ps_of(input logic [REG_W-1:0] d);
    return {d[B_PS3], d[B_PS2], d[B_PS1], d[B_PS0]};
  endfunction
endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock #(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic consume,
  output logic open
);
  localparam int CW = $clog2(WIN + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          left_q <= '0;
    else if (arm)        left_q <= CW'(WIN);
    else if (consume)    left_q <= '0;
    else if (left_q != '0) left_q <= left_q - CW'(1);
  end

  assign open = (left_q != '0);
endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctl,
  input  logic [REG_W-1:0] wdata,
  input  logic             open,
  input  logic             hw_ie_clr,
  output wdog_cfg_t        cfg,
  output logic             arm,
  output logic             applied,
  output logic             sw_ie_clr
);
  wdog_cfg_t cfg_q;

  assign arm       = wr_ctl & wdata[B_CE] & wdata[B_RE];
  assign applied   = wr_ctl & open & ~arm;
  assign sw_ie_clr = wr_ctl & ~wdata[B_IE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      if (applied) begin
        cfg_q.re <= wdata[B_RE];
        cfg_q.ps <= ps_of(wdata);
      end
      if (hw_ie_clr)   cfg_q.ie <= 1'b0;
      else if (wr_ctl) cfg_q.ie <= wdata[B_IE];
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int BASE_LOG2 = 11,
  parameter int SEL_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [SEL_W-1:0] ps,
  input  logic             tick,
  input  logic             clr,
  output logic             expire,
  output logic             cnt_idle
);
  localparam int CNT_W = BASE_LOG2 + (1 << SEL_W) - 1;
  localparam int SH_W  = $clog2(CNT_W + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic [SH_W-1:0]  shamt;
  logic             hit;

  assign shamt = SH_W'(BASE_LOG2) + SH_W'(ps);
  // at the largest select the shift leaves the word and the result wraps to all ones
  assign last  = (CNT_W'(1) << shamt) - CNT_W'(1);
  assign hit   = (cnt_q == last);
  assign expire = active & tick & ~clr & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!active || clr)   cnt_q <= '0;
    else if (tick)             cnt_q <= hit ? '0 : cnt_q + CNT_W'(1);
  end

  assign cnt_idle = (cnt_q == '0);
endmodule

// File: rtl/wdog_action.sv
module wdog_action (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic re,
  input  logic ie,
  input  logic irq_ack,
  input  logic sw_ie_clr,
  input  logic flag_wr,
  input  logic flag_wbit,
  output logic hw_ie_clr,
  output logic irq,
  output logic sys_rst,
  output logic flag
);
  logic irq_q, rst_q, flag_q;
  logic fire_irq, fire_rst;

  assign fire_irq  = expire & ie;
  assign fire_rst  = expire & re & ~ie;
  assign hw_ie_clr = fire_irq & re;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      rst_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      rst_q <= fire_rst;
      if (fire_irq)                  irq_q <= 1'b1;
      else if (irq_ack || sw_ie_clr) irq_q <= 1'b0;
      if (fire_rst)                  flag_q <= 1'b1;
      else if (flag_wr && !flag_wbit) flag_q <= 1'b0;
    end
  end

  assign irq     = irq_q;
  assign sys_rst = rst_q;
  assign flag    = flag_q;
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2  = 11,
  parameter int UNLOCK_WIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             restart,
  input  logic             irq_ack,
  input  logic             tick_en,
  output logic             irq,
  output logic             sys_rst
);
  wdog_cfg_t cfg;
  logic wr_ctl, wr_sts, arm, applied, sw_ie_clr, hw_ie_clr;
  logic win_open, expire, cnt_idle, flag, active;
  logic [REG_W-1:0] sts_image;
  logic unused_wdata;

  assign wr_ctl = reg_wr & ~reg_sel;
  assign wr_sts = reg_wr &  reg_sel;
  assign active = cfg.re | cfg.ie;
  assign unused_wdata = ^{reg_wdata[7:4], reg_wdata[2:0]};

  wdog_unlock #(.WIN(UNLOCK_WIN)) u_unlock (
    .clk(clk), .rst_n(rst_n), .arm(arm), .consume(applied), .open(win_open)
  );

  wdog_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wdata(reg_wdata),
    .open(win_open), .hw_ie_clr(hw_ie_clr), .cfg(cfg), .arm(arm),
    .applied(applied), .sw_ie_clr(sw_ie_clr)
  );

  wdog_timer #(.BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(active), .ps(cfg.ps), .tick(tick_en),
    .clr(restart | applied), .expire(expire), .cnt_idle(cnt_idle)
  );

  wdog_action u_action (
    .clk(clk), .rst_n(rst_n), .expire(expire), .re(cfg.re), .ie(cfg.ie),
    .irq_ack(irq_ack), .sw_ie_clr(sw_ie_clr), .flag_wr(wr_sts),
    .flag_wbit(reg_wdata[B_FLAG]), .hw_ie_clr(hw_ie_clr), .irq(irq),
    .sys_rst(sys_rst), .flag(flag)
  );

  always_comb begin
    sts_image         = '0;
    sts_image[B_FLAG] = flag;
  end

  assign reg_rdata = reg_sel ? sts_image : ctl_image(cfg, win_open);
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int WIN = 4
) (
  input logic clk,
  input logic rst_n,
  input logic sys_rst,
  input logic irq,
  input logic irq_ack,
  input logic sw_ie_clr,
  input logic restart,
  input logic flag,
  input logic re,
  input logic win_open,
  input logic arm,
  input logic cnt_idle
);
  int open_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        open_run <= 0;
    else if (arm)      open_run <= 0;
    else if (win_open) open_run <= open_run + 1;
    else               open_run <= 0;
  end

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> !sys_rst); // R6
  AST_RST_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> flag); // R6
  AST_RST_NEEDS_RE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> $past(re)); // R10
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack && !sw_ie_clr) |=> irq); // R9
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_idle); // R7
  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    open_run <= WIN); // R5
endmodule

bind wdog_top wdog_chk #(.WIN(UNLOCK_WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .irq(irq), .irq_ack(irq_ack),
  .sw_ie_clr(sw_ie_clr), .restart(restart), .flag(flag), .re(cfg.re),
  .win_open(win_open), .arm(arm), .cnt_idle(cnt_idle)
);

// File: tb/wdog_top_test.sv
module wdog_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       restart = 1'b0;
  logic       irq_ack = 1'b0;
  logic       tick_en = 1'b0;
  logic       irq, sys_rst;

  int checks = 0;
  int failures = 0;
  int pulses = 0;

  // bits [4:1] prescale select, bit [0] interrupt mode
  localparam logic [4:0] VEC [4] = '{5'b0000_0, 5'b0001_1, 5'b0010_0, 5'b0011_1};

  always #10 clk = ~clk;

  wdog_top uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .restart(restart),
    .irq_ack(irq_ack), .tick_en(tick_en), .irq(irq), .sys_rst(sys_rst)
  );

  always @(posedge clk) if (rst_n && sys_rst) pulses <= pulses + 1;

  function automatic logic [7:0] ctl(input logic [3:0] s, input logic re, input logic ie);
    return {1'b0, ie, s[3], 1'b0, re, s[2:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [7:0] d);
    reg_sel = s;
    #1 d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic pulse_ack();
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic unlock_write(input logic [7:0] d);
    wr(1'b0, 8'h18);
    wr(1'b0, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all-requirements actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int base;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rd(1'b0, d); chk("R1 ctl", d, 8'h00);
    rd(1'b1, d); chk("R1 sts", d, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 sys_rst", sys_rst, 0);

    // vector table: period per select and mode
    foreach (VEC[i]) begin
      logic [3:0] s;
      logic im;
      int n;
      s = VEC[i][4:1];
      im = VEC[i][0];
      n = 2048 << s;
      unlock_write(ctl(s, !im, im));
      if (irq) pulse_ack();
      wr(1'b1, 8'h00);
      rd(1'b0, d); chk("R2 ctl image", d, ctl(s, !im, im));
      base = pulses;
      ticks(n - 1);
      idle(50);
      chk("R3 no early event", pulses, base);
      chk("R3 no early irq", irq, 0);
      ticks(1);
      chk(im ? "R8 irq at period" : "R6 no irq in reset mode", irq, im);
      idle(2);
      chk(im ? "R8 no reset in irq mode" : "R6 one reset pulse", pulses, base + (im ? 0 : 1));
      rd(1'b1, d); chk("R6 flag", d, im ? 8'h00 : 8'h08);
    end
    if (irq) pulse_ack();
    wr(1'b1, 8'h00);

    // R4 / R5 unlock window
    unlock_write(8'h08);
    wr(1'b0, 8'h18);
    rd(1'b0, d); chk("R5 ce open", d, 8'h18);
    idle(4);
    rd(1'b0, d); chk("R5 ce closed", d, 8'h08);
    wr(1'b0, 8'h0F);
    rd(1'b0, d); chk("R4 late write ignored", d, 8'h08);
    wr(1'b0, 8'h18);
    idle(3);
    wr(1'b0, 8'h0F);
    rd(1'b0, d); chk("R4 write at 4 cycles taken", d, 8'h0F);
    wr(1'b0, 8'h00);
    rd(1'b0, d); chk("R4 unarmed write ignored", d, 8'h0F);

    // R7 restart
    unlock_write(8'h08);
    base = pulses;
    ticks(2000);
    restart = 1'b1; @(negedge clk); restart = 1'b0;
    ticks(2047);
    idle(2);
    chk("R7 no reset before full period", pulses, base);
    ticks(1);
    idle(2);
    chk("R7 reset one period after restart", pulses, base + 1);

    // R12 restart against terminal tick
    unlock_write(8'h08);
    base = pulses;
    ticks(2047);
    tick_en = 1'b1; restart = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; restart = 1'b0;
    idle(2);
    chk("R12 restart wins", pulses, base);
    ticks(2047);
    idle(2);
    chk("R12 no early reset", pulses, base);
    ticks(1);
    idle(2);
    chk("R12 reset after full period", pulses, base + 1);

    // R8 interrupt plus reset
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h18);
    wr(1'b0, 8'h48);
    rd(1'b0, d); chk("R13 ctl both enables", d, 8'h48);
    base = pulses;
    ticks(2048);
    chk("R8 first timeout irq", irq, 1);
    idle(2);
    chk("R8 first timeout no reset", pulses, base);
    rd(1'b0, d); chk("R8 ie cleared by hw", d, 8'h08);
    chk("R9 irq held", irq, 1);
    pulse_ack();
    chk("R9 ack clears irq", irq, 0);
    ticks(2048);
    idle(2);
    chk("R8 second timeout resets", pulses, base + 1);
    chk("R8 second timeout no irq", irq, 0);

    // R9 software clear, R13 unprotected ie
    wr(1'b0, 8'h48);
    rd(1'b0, d); chk("R13 ie set outside window", d, 8'h48);
    ticks(2048);
    idle(3);
    chk("R9 irq held without ack", irq, 1);
    wr(1'b0, 8'h08);
    chk("R9 ie-clear write drops irq", irq, 0);

    // R11 flag clearing
    rd(1'b1, d); chk("R11 flag set", d, 8'h08);
    wr(1'b1, 8'hFF);
    rd(1'b1, d); chk("R11 write 1 no effect", d, 8'h08);
    wr(1'b1, 8'h00);
    rd(1'b1, d); chk("R11 write 0 clears", d, 8'h00);

    // R10 disable via unlock
    unlock_write(8'h00);
    rd(1'b0, d); chk("R10 ctl off", d, 8'h00);
    base = pulses;
    ticks(10000);
    idle(2);
    chk("R10 no reset when off", pulses, base);
    chk("R10 no irq when off", irq, 0);
    rd(1'b1, d); chk("R10 flag unchanged", d, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule